// File: doc/BRIEF.md
# System Clock Divider and Selector

This block runs entirely in the fast synthesized clock domain and derives the system, serial-sync, baud-rate and external-bus clocks from it. Each derived clock appears as a single-cycle enable pulse (a tick) and as a 50% duty observation clock that toggles on every tick. One free-running counter sets the phase of every pulse. A divisor of D therefore fires on each cycle where the count of fast cycles since reset, modulo D, equals D-1.

The system clock has two separate division factors, one for high-speed running and one for low-power running. A source-select bit picks between them. A wake-enable bit together with a coprocessor-active input forces the high-speed factor. A two-state machine tracks which factor is applied. It starts in `ST_HS` and moves to `ST_LP` when low power is requested and both the current and the new divided clocks are at a shared pulse. It returns from `ST_LP` to `ST_HS` under the same shared-pulse condition once low power is no longer requested. The bus clock is the system clock divided by 1 or 2. The external clock pin follows the bus observation clock, runs at a selectable drive strength, or is held high when disabled.

The control fields come in through a write strobe. A write carrying a reserved code leaves that field unchanged. Reset clears every field, except that the bus field takes its value from a configuration input.

Top module: `sysclk_divsel`

## Requirements
- R1: While reset is asserted, and after it is released until the first write, every field is zero except the bus field, which equals `cfg_bus_half`. The sys, serial and baud lanes tick every cycle, all observation clocks are 0, `sys_lp_active` is 0 and `clkout_half` is 0.
- R2: High-speed code c (0 to 6) divides the system clock by 2^c. A write of code 7 leaves the field unchanged.
- R3: Low-power code c (0 to 5) divides by 2^(c+1) and code 7 divides by 256. A write of code 6 leaves the field unchanged.
- R4: The system uses the low-power factor, and `sys_lp_active` is 1, only when the source bit is 1. Otherwise it uses the high-speed factor.
- R5: While the wake-enable bit is 1 and `cop_active` is 1, the system uses the high-speed factor even if the source bit is 1.
- R6: Serial and baud codes 0, 1, 2 and 3 divide by 1, 4, 16 and 64.
- R7: Bus code 0 gives a bus tick on every system tick. Code 1 gives a bus tick on every second system tick. Codes 2 and 3 are ignored.
- R8: Output code 0 drives the bus observation clock at full strength and code 1 drives it at half strength (`clkout_half`=1). Code 3 holds the pin at 1. Code 2 is ignored. A new code takes effect only at a bus tick where the bus observation clock is 1.
- R9: A new divisor on any lane takes effect only in a cycle where both the old and the new divisor pulse. No interval between ticks is therefore shorter than the smaller of the two periods.
- R10: A divisor D pulses when (fast cycles since reset) mod D equals D-1. Each observation clock toggles on every tick of its lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast synthesized clock |
| rst_n | input | 1 | Power-on or hard reset, active low, asynchronous |
| cfg_bus_half | input | 1 | Reset value of the bus divide field (1 = divide by 2) |
| cop_active | input | 1 | Coprocessor activity, requests a wake to high speed |
| ctl_we | input | 1 | Write strobe for the control fields |
| hs_div_in | input | 3 | High-speed division code |
| lp_div_in | input | 3 | Low-power division code |
| src_lp_in | input | 1 | Source select, 1 = low-power factor |
| wake_en_in | input | 1 | Enables the wake on `cop_active` |
| ser_div_in | input | 2 | Serial-sync division code |
| brg_div_in | input | 2 | Baud-rate division code |
| bus_div_in | input | 2 | Bus division code |
| clkout_ctl_in | input | 2 | External clock pin control code |
| sys_tick | output | 1 | System clock enable pulse |
| sys_clk | output | 1 | System observation clock |
| sys_lp_active | output | 1 | Low-power factor applied (`ST_LP`) |
| ser_tick | output | 1 | Serial-sync enable pulse |
| ser_clk | output | 1 | Serial-sync observation clock |
| brg_tick | output | 1 | Baud-rate enable pulse |
| brg_clk | output | 1 | Baud-rate observation clock |
| bus_tick | output | 1 | External bus enable pulse |
| bus_clk | output | 1 | Bus observation clock |
| clkout_pin | output | 1 | External clock pin level |
| clkout_half | output | 1 | Half-strength drive request |

## Verification
The bench steps the high-speed factor through small, large and reserved codes, so that pulse spacing, switch points and ignored writes can be told apart. It then selects the low-power factor up to divide by 256 and toggles `cop_active` with wake enabled and disabled. This separates a plain source switch from a wake override. The serial, baud, bus and pin-control codes are changed in mid-run, including the reserved codes and a reset with each configuration value. A behavioural model that counts cycles since reset predicts every tick, observation clock and pin level, and the bench compares all of them on every cycle. Late or early switch points therefore show up directly.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
    localparam int CNT_W = 8;
    localparam int EXP_W = 4;

    typedef enum logic {ST_HS, ST_LP} sys_mode_e;

    // Pulse when the low e bits of the shared counter are all ones.
    function automatic logic lane_pulse(input logic [CNT_W-1:0] cnt,
                                        input logic [EXP_W-1:0] e);
        logic [CNT_W:0] m;
        m = ((CNT_W+1)'(1) << e) - (CNT_W+1)'(1);
        return (cnt & m[CNT_W-1:0]) == m[CNT_W-1:0];
    endfunction

    function automatic logic [EXP_W-1:0] exp_max(input logic [EXP_W-1:0] a,
                                                 input logic [EXP_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [EXP_W-1:0] hs_exp(input logic [2:0] code);
        return EXP_W'(code);
    endfunction

    function automatic logic [EXP_W-1:0] lp_exp(input logic [2:0] code);
        return (code == 3'd7) ? EXP_W'(8) : EXP_W'(code) + EXP_W'(1);
    endfunction

    function automatic logic [EXP_W-1:0] quad_exp(input logic [1:0] code);
        return EXP_W'({code, 1'b0});
    endfunction
endpackage

// File: rtl/div_lane.sv
module div_lane
    import sysclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [EXP_W-1:0] req_exp,
    output logic             tick,
    output logic             clk_obs
);
    logic [EXP_W-1:0] act_exp;
    logic             joint;

    always_comb begin
        joint = lane_pulse(cnt, exp_max(act_exp, req_exp));
        tick  = lane_pulse(cnt, act_exp);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_exp <= '0;
            clk_obs <= 1'b0;
        end else begin
            if (joint) act_exp <= req_exp;
            if (tick)  clk_obs <= ~clk_obs;
        end
    end

    AST_LANE_SWITCH_AT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (act_exp != $past(act_exp)) |-> $past(tick)); // R9
endmodule

// File: rtl/sysclk_mode_fsm.sv
module sysclk_mode_fsm
    import sysclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [EXP_W-1:0] hs_e,
    input  logic [EXP_W-1:0] lp_e,
    input  logic             want_lp,
    output logic             sys_tick,
    output logic             sys_obs,
    output logic             lp_active
);
    sys_mode_e        state, state_nx;
    logic [EXP_W-1:0] act_exp, act_nx, tgt_exp;
    logic             joint;

    always_comb begin
        tgt_exp  = want_lp ? lp_e : hs_e;
        joint    = lane_pulse(cnt, exp_max(act_exp, tgt_exp));
        state_nx = state;
        act_nx   = joint ? tgt_exp : act_exp;
        unique case (state)
            ST_HS: if (joint && want_lp)  state_nx = ST_LP;
            ST_LP: if (joint && !want_lp) state_nx = ST_HS;
            default: state_nx = ST_HS;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_HS;
            act_exp <= '0;
            sys_obs <= 1'b0;
        end else begin
            state   <= state_nx;
            act_exp <= act_nx;
            if (sys_tick) sys_obs <= ~sys_obs;
        end
    end

    always_comb begin
        lp_active = (state == ST_LP);
        sys_tick  = lane_pulse(cnt, act_exp);
    end

    AST_LP_ENTRY_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lp_active) |-> $past(want_lp)); // R4
    AST_SYS_SWITCH_AT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (act_exp != $past(act_exp)) |-> $past(sys_tick)); // R9
endmodule

// File: rtl/bus_clk_gen.sv
module bus_clk_gen (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_bus_half,
    input  logic       sys_tick,
    input  logic       half_req,
    input  logic [1:0] com_req,
    output logic       bus_tick,
    output logic       bus_obs,
    output logic       pin,
    output logic       half_drive
);
    logic       phase, half_act;
    logic [1:0] com_act;

    always_comb begin
        bus_tick   = sys_tick && (!half_act || phase);
        pin        = (com_act == 2'b11) || bus_obs;
        half_drive = (com_act == 2'b01);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase    <= 1'b0;
            half_act <= cfg_bus_half;
            bus_obs  <= 1'b0;
            com_act  <= 2'b00;
        end else begin
            if (sys_tick && phase)   half_act <= half_req;
            if (sys_tick)            phase    <= ~phase;
            if (bus_tick)            bus_obs  <= ~bus_obs;
            if (bus_tick && bus_obs) com_act  <= com_req;
        end
    end

    AST_BUS_SWITCH_AT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (half_act != $past(half_act)) |-> $past(sys_tick && phase)); // R7
    AST_PIN_CTL_AT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (com_act != $past(com_act)) |-> $past(bus_tick && bus_obs)); // R8
endmodule

// File: rtl/sysclk_divsel.sv
module sysclk_divsel
    import sysclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_bus_half,
    input  logic       cop_active,
    input  logic       ctl_we,
    input  logic [2:0] hs_div_in,
    input  logic [2:0] lp_div_in,
    input  logic       src_lp_in,
    input  logic       wake_en_in,
    input  logic [1:0] ser_div_in,
    input  logic [1:0] brg_div_in,
    input  logic [1:0] bus_div_in,
    input  logic [1:0] clkout_ctl_in,
    output logic       sys_tick,
    output logic       sys_clk,
    output logic       sys_lp_active,
    output logic       ser_tick,
    output logic       ser_clk,
    output logic       brg_tick,
    output logic       brg_clk,
    output logic       bus_tick,
    output logic       bus_clk,
    output logic       clkout_pin,
    output logic       clkout_half
);
    logic [CNT_W-1:0] cnt;
    logic [2:0]       hs_q, lp_q;
    logic [1:0]       ser_q, brg_q, com_q;
    logic             src_q, wake_q, bus_half_q, want_lp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt        <= '0;
            hs_q       <= '0;
            lp_q       <= '0;
            ser_q      <= '0;
            brg_q      <= '0;
            com_q      <= '0;
            src_q      <= 1'b0;
            wake_q     <= 1'b0;
            bus_half_q <= cfg_bus_half;
        end else begin
            cnt <= cnt + CNT_W'(1);
            if (ctl_we) begin
                if (hs_div_in != 3'd7)      hs_q       <= hs_div_in;
                if (lp_div_in != 3'd6)      lp_q       <= lp_div_in;
                if (!bus_div_in[1])         bus_half_q <= bus_div_in[0];
                if (clkout_ctl_in != 2'b10) com_q      <= clkout_ctl_in;
                src_q  <= src_lp_in;
                wake_q <= wake_en_in;
                ser_q  <= ser_div_in;
                brg_q  <= brg_div_in;
            end
        end
    end

    always_comb want_lp = src_q && !(wake_q && cop_active);

    sysclk_mode_fsm u_mode (
        .clk(clk), .rst_n(rst_n), .cnt(cnt),
        .hs_e(hs_exp(hs_q)), .lp_e(lp_exp(lp_q)), .want_lp(want_lp),
        .sys_tick(sys_tick), .sys_obs(sys_clk), .lp_active(sys_lp_active)
    );

    div_lane u_ser (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .req_exp(quad_exp(ser_q)),
        .tick(ser_tick), .clk_obs(ser_clk)
    );

    div_lane u_brg (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .req_exp(quad_exp(brg_q)),
        .tick(brg_tick), .clk_obs(brg_clk)
    );

    bus_clk_gen u_bus (
        .clk(clk), .rst_n(rst_n), .cfg_bus_half(cfg_bus_half),
        .sys_tick(sys_tick), .half_req(bus_half_q), .com_req(com_q),
        .bus_tick(bus_tick), .bus_obs(bus_clk), .pin(clkout_pin),
        .half_drive(clkout_half)
    );

    AST_HS_RESERVED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && hs_div_in == 3'd7) |=> (hs_q == $past(hs_q))); // R2
    AST_LP_RESERVED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && lp_div_in == 3'd6) |=> (lp_q == $past(lp_q))); // R3
    AST_WAKE_BLOCKS_LP: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_q && cop_active) |=> !$rose(sys_lp_active)); // R5
endmodule

// File: tb/test_sysclk_divsel.sv
module test_sysclk_divsel;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_bus_half = 1'b1;
    logic cop_active = 1'b0;
    logic ctl_we = 1'b0;
    logic [2:0] hs_div_in = '0, lp_div_in = '0;
    logic src_lp_in = 1'b0, wake_en_in = 1'b0;
    logic [1:0] ser_div_in = '0, brg_div_in = '0, bus_div_in = '0, clkout_ctl_in = '0;
    logic sys_tick, sys_clk, sys_lp_active, ser_tick, ser_clk, brg_tick, brg_clk;
    logic bus_tick, bus_clk, clkout_pin, clkout_half;

    always #4 clk = ~clk;

    sysclk_divsel i_sysclk_divsel (.*);

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 0;

    // behavioural reference state
    int n, ds, dser, dbrg, db, comA;
    int f_hs, f_lp, f_ser, f_brg, f_bus, f_com, f_src, f_wk;
    bit mlp, bp, sobs, serobs, brgobs, bobs;

    function automatic int hsd(int c);  return 1 << c; endfunction
    function automatic int lpd(int c);  return (c == 7) ? 256 : (2 << c); endfunction
    function automatic int qd(int c);   return 1 << (2 * c); endfunction
    function automatic bit fires(int cnt, int d); return (cnt % d) == d - 1; endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n = 0; ds = 1; dser = 1; dbrg = 1; db = cfg_bus_half ? 2 : 1; comA = 0;
            f_hs = 0; f_lp = 0; f_ser = 0; f_brg = 0; f_bus = cfg_bus_half; f_com = 0;
            f_src = 0; f_wk = 0; mlp = 0; bp = 0;
            sobs = 0; serobs = 0; brgobs = 0; bobs = 0;
        end else begin
            bit st, sr, bg, bt, wl;
            int tgt, m;
            st = fires(n, ds); sr = fires(n, dser); bg = fires(n, dbrg);
            bt = st && (db == 1 || bp);
            wl = f_src != 0 && !(f_wk != 0 && cop_active);
            tgt = wl ? lpd(f_lp) : hsd(f_hs);
            m = (tgt > ds) ? tgt : ds;
            if (fires(n, m)) begin ds = tgt; mlp = wl; end
            m = (qd(f_ser) > dser) ? qd(f_ser) : dser;
            if (fires(n, m)) dser = qd(f_ser);
            m = (qd(f_brg) > dbrg) ? qd(f_brg) : dbrg;
            if (fires(n, m)) dbrg = qd(f_brg);
            if (bt && bobs) comA = f_com;
            if (st && bp) db = f_bus ? 2 : 1;
            if (st) bp = !bp;
            if (st) sobs = !sobs;
            if (sr) serobs = !serobs;
            if (bg) brgobs = !brgobs;
            if (bt) bobs = !bobs;
            if (ctl_we) begin
                if (hs_div_in != 7) f_hs = hs_div_in;
                if (lp_div_in != 6) f_lp = lp_div_in;
                if (!bus_div_in[1]) f_bus = bus_div_in[0];
                if (clkout_ctl_in != 2) f_com = clkout_ctl_in;
                f_src = src_lp_in; f_wk = wake_en_in;
                f_ser = ser_div_in; f_brg = brg_div_in;
            end
            n = (n + 1) % 256;
        end
    end

    task automatic check(input string tag, input bit act, input bit exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %0b expected %0b", tag, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n && !done) begin
            bit st;
            st = fires(n, ds);
            check("R2/R3/R10 sys_tick", sys_tick, st);
            check("R10 sys_clk", sys_clk, sobs);
            check("R4/R5 sys_lp_active", sys_lp_active, mlp);
            check("R6/R9 ser_tick", ser_tick, fires(n, dser));
            check("R6 ser_clk", ser_clk, serobs);
            check("R6/R9 brg_tick", brg_tick, fires(n, dbrg));
            check("R6 brg_clk", brg_clk, brgobs);
            check("R7 bus_tick", bus_tick, st && (db == 1 || bp));
            check("R7 bus_clk", bus_clk, bobs);
            check("R8 clkout_pin", clkout_pin, (comA == 3) ? 1'b1 : bobs);
            check("R8 clkout_half", clkout_half, comA == 1);
        end
        if (cyc >= 200000 && !done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic run(input int k);
        repeat (k) @(posedge clk);
        #1;
    endtask

    task automatic wr;
        @(posedge clk); #1 ctl_we = 1'b1;
        @(posedge clk); #1 ctl_we = 1'b0;
    endtask

    initial begin
        // R1 and R7: reset state with the bus field loaded from configuration
        run(3); rst_n = 1'b1; run(30);
        // R2 and R9: high-speed factors, including the reserved code
        hs_div_in = 3; wr(); run(60);
        hs_div_in = 7; wr(); run(40);
        hs_div_in = 6; wr(); run(300);
        hs_div_in = 0; wr(); run(150);
        // R3 and R4: low-power factors, divide by 256, reserved code
        lp_div_in = 7; src_lp_in = 1; wr(); run(800);
        lp_div_in = 6; wr(); run(300);
        lp_div_in = 2; wr(); run(100);
        // R5: wake on coprocessor activity, and without wake enable
        cop_active = 1; run(60);
        wake_en_in = 1; wr(); run(80);
        cop_active = 0; run(80);
        cop_active = 1; run(40);
        src_lp_in = 0; wake_en_in = 0; cop_active = 0; wr(); run(60);
        // R6: serial and baud codes
        ser_div_in = 1; brg_div_in = 3; wr(); run(200);
        ser_div_in = 3; brg_div_in = 0; wr(); run(200);
        ser_div_in = 2; brg_div_in = 2; wr(); run(100);
        // R7: bus divide codes, reserved ignored
        hs_div_in = 1; bus_div_in = 0; wr(); run(50);
        bus_div_in = 2; wr(); run(30);
        bus_div_in = 1; wr(); run(50);
        // R8: pin control codes
        clkout_ctl_in = 1; wr(); run(30);
        clkout_ctl_in = 2; wr(); run(30);
        clkout_ctl_in = 3; wr(); run(40);
        clkout_ctl_in = 0; wr(); run(40);
        // R1: reset again with the other configuration value
        cfg_bus_half = 0; rst_n = 0; run(3); rst_n = 1; run(40);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule